// File: doc/BRIEF.md
# DMA Controller Global Control Registers

This block keeps the controller-wide control state of a four-channel DMA engine. A host reaches it through eight byte-wide control ports, selected by a 3-bit offset, and uses them to load a command byte, raise or drop software transfer requests, mask channels one at a time or all at once, program a mode byte per channel, clear the shared byte pointer and return the block to its reset state. Two ports can be read back: the status byte and the channel mask.

The transfer engine sits beside it. It receives the mask, the request nibble, the per-channel mode bytes and three decoded mode flags (auto-initialise, address decrement, verify), and it drives back per-channel terminal-count pulses, hold and release levels for hardware requests, and a toggle for the byte pointer that its address and count ports use. The status byte merges pending requests (upper nibble) with terminal-count flags (lower nibble); a status read hands the host the whole byte and then clears only the terminal-count flags.

Top module: `dma_ctl_regs`

## Requirements
- R1: After hardware reset the mask is 4'hF, command, status and byte pointer are 0, every mode byte is 0 (so every verify flag is 1).
- R2: A write to offset 0 loads the command only when the value is 8'h00 or 8'h04; any other value leaves the command unchanged.
- R3: A write to offset 1 with channel c = data[1:0] sets status bit c+4 to data[2] and clears status bit c; status bits 7:4 are driven on req_o.
- R4: A write to offset 2 sets mask bit data[1:0] when data[2] is 1 and clears it when data[2] is 0; the other mask bits keep their value.
- R5: A write to offset 3 stores the whole byte as the mode of channel data[1:0] (mode_o bits 8c+7..8c); autoinit_o[c] is mode bit 4, decr_o[c] is mode bit 5, verify_o[c] is 1 when mode bits 3:2 are 00.
- R6: A write to offset 4 clears the byte pointer; a ptr_toggle pulse otherwise inverts it.
- R7: A write to offset 5 clears byte pointer, status and command and sets all four mask bits, overriding every other update in that cycle; mode bytes are kept.
- R8: A write to offset 6 clears the mask; a write to offset 7 loads the mask from data[3:0].
- R9: A read of offset 0 returns the status byte in the same cycle and then clears status bits 3:0 while bits 7:4 keep their value.
- R10: hold_set[c] sets status bit c+4 and hold_clr[c] clears it; when both are high for one channel the set wins, and both take precedence over a request write in the same cycle.
- R11: tc_pulse[c] sets status bit c; it takes precedence over a same-cycle status read or request write.
- R12: A read of offset 1 returns {4'b0, mask}; reads of offsets 2 to 7, and ctl_rdata whenever ctl_rd is low, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control port write strobe |
| ctl_rd | input | 1 | Control port read strobe |
| ctl_sel | input | 3 | Control port offset |
| ctl_wdata | input | 8 | Write data |
| ctl_rdata | output | 8 | Read data, valid in the cycle of ctl_rd |
| ptr_toggle | input | 1 | Byte pointer toggle from the address/count ports |
| tc_pulse | input | 4 | Per-channel terminal-count pulses |
| hold_set | input | 4 | Per-channel hardware request hold |
| hold_clr | input | 4 | Per-channel hardware request release |
| cmd_o | output | 8 | Command byte |
| mask_o | output | 4 | Channel mask, 1 = masked |
| req_o | output | 4 | Pending request bits (status 7:4) |
| mode_o | output | 32 | Mode bytes, channel c in bits 8c+7..8c |
| autoinit_o | output | 4 | Auto-initialise flag per channel |
| decr_o | output | 4 | Address decrement flag per channel |
| verify_o | output | 4 | Verify-transfer flag per channel |
| byte_ptr_o | output | 1 | Byte pointer |

## Verification
The status byte is the point where two functions collide: a host status read or request write can land in the same cycle as a terminal-count pulse or a hold/release level for the same channel. The bench provokes this directly, with a status read issued together with a terminal-count pulse and a request write issued together with hold inputs, and then in random traffic where reads, writes and engine inputs overlap freely. Each collision is judged by the read data returned in that cycle and by the status read back afterwards, against a model that applies the stated precedence.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int NCH = 4;
  localparam int CHW = $clog2(NCH);
  localparam int DW  = 8;
  localparam int SW  = 2 * NCH;
  localparam int PW  = 3;
  localparam int NPORT = 1 << PW;

  typedef enum logic [PW-1:0] {
    OFS_CMD    = 3'd0,
    OFS_REQ    = 3'd1,
    OFS_SMASK  = 3'd2,
    OFS_MODE   = 3'd3,
    OFS_CLRPTR = 3'd4,
    OFS_MRST   = 3'd5,
    OFS_CLRMSK = 3'd6,
    OFS_WRMSK  = 3'd7
  } ofs_e;

  // command bits the block accepts; every other bit rejects the word
  localparam logic [DW-1:0] CMD_ALLOWED = 8'h04;

  function automatic logic cmd_accept(input logic [DW-1:0] v);
    return (v & ~CMD_ALLOWED) == '0;
  endfunction
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
(
  input  logic            wr,
  input  logic            rd,
  input  logic [PW-1:0]   sel,
  output logic [NPORT-1:0] wr_stb,
  output logic            rd_status,
  output logic            rd_mask
);
  for (genvar p = 0; p < NPORT; p++) begin : g_stb
    assign wr_stb[p] = wr && (sel == PW'(p));
  end
  assign rd_status = rd && (sel == OFS_CMD);
  assign rd_mask   = rd && (sel == OFS_REQ);
endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status
  import dma_ctl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mrst,
  input  logic           req_wr,
  input  logic [CHW-1:0] req_ch,
  input  logic           req_val,
  input  logic           rd_clr,
  input  logic [NCH-1:0] tc,
  input  logic [NCH-1:0] hset,
  input  logic [NCH-1:0] hclr,
  output logic [SW-1:0]  status_q
);
  logic [SW-1:0] status_n;
  logic          status_en;

  // fixed precedence: read clear, request write, hold levels, tc, reset
  always_comb begin
    status_n = status_q;
    if (rd_clr) status_n[NCH-1:0] = '0;
    if (req_wr) begin
      status_n[NCH + int'(req_ch)] = req_val;
      status_n[int'(req_ch)]       = 1'b0;
    end
    status_n[SW-1:NCH] = (status_n[SW-1:NCH] & ~hclr) | hset;
    status_n[NCH-1:0]  = status_n[NCH-1:0] | tc;
    if (mrst) status_n = '0;
  end

  assign status_en = mrst | rd_clr | req_wr | (|tc) | (|hset) | (|hclr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_n;
  end
endmodule

// File: rtl/dma_ctl_chan.sv
module dma_ctl_chan
  import dma_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mrst,
  input  logic            smask_wr,
  input  logic            mode_wr,
  input  logic            clrmsk_wr,
  input  logic            wrmsk_wr,
  input  logic [DW-1:0]   wdata,
  output logic [NCH-1:0]  mask_q,
  output logic [NCH*DW-1:0] mode_q,
  output logic [NCH-1:0]  autoinit,
  output logic [NCH-1:0]  decr,
  output logic [NCH-1:0]  verify
);
  logic [NCH-1:0] mask_n;
  logic           mask_en;

  always_comb begin
    mask_n = mask_q;
    if (mrst)           mask_n = '1;
    else if (clrmsk_wr) mask_n = '0;
    else if (wrmsk_wr)  mask_n = wdata[NCH-1:0];
    else if (smask_wr)  mask_n[int'(wdata[CHW-1:0])] = wdata[2];
  end

  assign mask_en = mrst | clrmsk_wr | wrmsk_wr | smask_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_n;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    logic          mode_en;
    logic [DW-1:0] mode_r;

    assign mode_en = mode_wr && (wdata[CHW-1:0] == CHW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_r <= '0;
      else if (mode_en) mode_r <= wdata;
    end

    assign mode_q[c*DW +: DW] = mode_r;
    assign autoinit[c] = mode_r[4];
    assign decr[c]     = mode_r[5];
    assign verify[c]   = (mode_r[3:2] == 2'b00);
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic [2:0]        ctl_sel,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              ptr_toggle,
  input  logic [3:0]        tc_pulse,
  input  logic [3:0]        hold_set,
  input  logic [3:0]        hold_clr,
  output logic [7:0]        cmd_o,
  output logic [3:0]        mask_o,
  output logic [3:0]        req_o,
  output logic [31:0]       mode_o,
  output logic [3:0]        autoinit_o,
  output logic [3:0]        decr_o,
  output logic [3:0]        verify_o,
  output logic              byte_ptr_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  logic [NPORT-1:0] wr_stb;
  logic             rd_status, rd_mask;

  dma_ctl_decode u_dec (
    .wr        (ctl_wr),
    .rd        (ctl_rd),
    .sel       (ctl_sel),
    .wr_stb    (wr_stb),
    .rd_status (rd_status),
    .rd_mask   (rd_mask)
  );

  logic mrst;
  assign mrst = wr_stb[OFS_MRST];

  logic [SW-1:0] status_q;

  dma_ctl_status u_status (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .mrst     (mrst),
    .req_wr   (wr_stb[OFS_REQ]),
    .req_ch   (ctl_wdata[CHW-1:0]),
    .req_val  (ctl_wdata[2]),
    .rd_clr   (rd_status),
    .tc       (tc_pulse),
    .hset     (hold_set),
    .hclr     (hold_clr),
    .status_q (status_q)
  );

  dma_ctl_chan u_chan (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .mrst      (mrst),
    .smask_wr  (wr_stb[OFS_SMASK]),
    .mode_wr   (wr_stb[OFS_MODE]),
    .clrmsk_wr (wr_stb[OFS_CLRMSK]),
    .wrmsk_wr  (wr_stb[OFS_WRMSK]),
    .wdata     (ctl_wdata),
    .mask_q    (mask_o),
    .mode_q    (mode_o),
    .autoinit  (autoinit_o),
    .decr      (decr_o),
    .verify    (verify_o)
  );

  // command register
  logic [DW-1:0] cmd_q, cmd_n;
  logic          cmd_en;

  always_comb begin
    cmd_en = mrst | (wr_stb[OFS_CMD] && cmd_accept(ctl_wdata));
    cmd_n  = mrst ? '0 : ctl_wdata;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_n;
  end

  // byte pointer
  logic ptr_q, ptr_n, ptr_en;

  always_comb begin
    ptr_en = mrst | wr_stb[OFS_CLRPTR] | ptr_toggle;
    ptr_n  = (mrst | wr_stb[OFS_CLRPTR]) ? 1'b0 : ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    ptr_q <= 1'b0;
    else if (ptr_en) ptr_q <= ptr_n;
  end

  // read mux
  always_comb begin
    ctl_rdata = '0;
    if (rd_status)    ctl_rdata = status_q;
    else if (rd_mask) ctl_rdata = {{(DW-NCH){1'b0}}, mask_o};
  end

  assign cmd_o      = cmd_q;
  assign req_o      = status_q[SW-1:NCH];
  assign byte_ptr_o = ptr_q;
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic       ctl_rd,
  input logic [2:0] ctl_sel,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic [3:0] tc_pulse,
  input logic [3:0] hold_set,
  input logic [7:0] cmd_o,
  input logic [3:0] mask_o,
  input logic [7:0] status_q,
  input logic       byte_ptr_o
);
  logic mrst_w;
  assign mrst_w = ctl_wr && (ctl_sel == 3'd5);

  p_cmd_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_sel == 3'd0 && (ctl_wdata & 8'hFB) != 8'h00) |=> $stable(cmd_o));

  p_single_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_sel == 3'd2) |=>
      ((mask_o >> $past(ctl_wdata[1:0])) & 4'h1) == {3'b000, $past(ctl_wdata[2])});

  p_master_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_w |=> (mask_o == 4'hF && cmd_o == 8'h00 && status_q == 8'h00 && !byte_ptr_o));

  p_write_all_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_sel == 3'd7) |=> mask_o == $past(ctl_wdata[3:0]));

  p_status_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && ctl_sel == 3'd0 && tc_pulse == 4'h0) |=> status_q[3:0] == 4'h0);

  p_hold_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hold_set) && !mrst_w) |=> (status_q[7:4] & $past(hold_set)) == $past(hold_set));

  p_tc_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tc_pulse) && !mrst_w) |=> (status_q[3:0] & $past(tc_pulse)) == $past(tc_pulse));

  p_unused_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rd || ctl_sel > 3'd1) |-> ctl_rdata == 8'h00);
endmodule

bind dma_ctl_regs dma_ctl_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_rd     (ctl_rd),
  .ctl_sel    (ctl_sel),
  .ctl_wdata  (ctl_wdata),
  .ctl_rdata  (ctl_rdata),
  .tc_pulse   (tc_pulse),
  .hold_set   (hold_set),
  .cmd_o      (cmd_o),
  .mask_o     (mask_o),
  .status_q   (status_q),
  .byte_ptr_o (byte_ptr_o)
);

// File: tb/dma_ctl_regs_tb.sv
module dma_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr, ctl_rd, ptr_toggle;
  logic [2:0]  ctl_sel;
  logic [7:0]  ctl_wdata, ctl_rdata, cmd_o;
  logic [3:0]  tc_pulse, hold_set, hold_clr;
  logic [3:0]  mask_o, req_o, autoinit_o, decr_o, verify_o;
  logic [31:0] mode_o;
  logic        byte_ptr_o;

  always #2.5 clk = ~clk;

  dma_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ptr_toggle(ptr_toggle), .tc_pulse(tc_pulse), .hold_set(hold_set),
    .hold_clr(hold_clr), .cmd_o(cmd_o), .mask_o(mask_o), .req_o(req_o),
    .mode_o(mode_o), .autoinit_o(autoinit_o), .decr_o(decr_o),
    .verify_o(verify_o), .byte_ptr_o(byte_ptr_o)
  );

  int n_vec = 0;
  int n_err = 0;
  bit done  = 0;

  // model state
  logic [7:0] m_cmd, m_status;
  logic [3:0] m_mask;
  logic [7:0] m_mode [4];
  logic       m_ptr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_verify();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) v[c] = (m_mode[c][3:2] == 2'b00);
    return v;
  endfunction

  task automatic check_outputs();
    chk("R2 cmd", {24'h0, cmd_o}, {24'h0, m_cmd});
    chk("R4 mask", {28'h0, mask_o}, {28'h0, m_mask});
    chk("R3 req", {28'h0, req_o}, {28'h0, m_status[7:4]});
    chk("R5 mode", mode_o, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
    chk("R5 autoinit", {28'h0, autoinit_o},
        {28'h0, m_mode[3][4], m_mode[2][4], m_mode[1][4], m_mode[0][4]});
    chk("R5 decr", {28'h0, decr_o},
        {28'h0, m_mode[3][5], m_mode[2][5], m_mode[1][5], m_mode[0][5]});
    chk("R5 verify", {28'h0, verify_o}, {28'h0, exp_verify()});
    chk("R6 ptr", {31'h0, byte_ptr_o}, {31'h0, m_ptr});
  endtask

  // one clock: drive at negedge, check read data, update model, check state
  task automatic cyc(input bit wr, input bit rd, input logic [2:0] sel,
                     input logic [7:0] d, input logic [3:0] tc,
                     input logic [3:0] hs, input logic [3:0] hc, input bit tg);
    logic [7:0] exp_rd, ns;
    logic [3:0] nm;
    int ch;
    @(negedge clk);
    ctl_wr = wr; ctl_rd = rd; ctl_sel = sel; ctl_wdata = d;
    tc_pulse = tc; hold_set = hs; hold_clr = hc; ptr_toggle = tg;
    #1;
    exp_rd = 8'h00;
    if (rd && sel == 3'd0) exp_rd = m_status;
    if (rd && sel == 3'd1) exp_rd = {4'h0, m_mask};
    chk((rd && sel <= 3'd1) ? "R9 read" : "R12 read", {24'h0, ctl_rdata}, {24'h0, exp_rd});
    ch = int'(d[1:0]);
    ns = m_status;
    nm = m_mask;
    if (rd && sel == 3'd0) ns[3:0] = 4'h0;
    if (wr && sel == 3'd1) begin ns[ch+4] = d[2]; ns[ch] = 1'b0; end
    ns[7:4] = (ns[7:4] & ~hc) | hs;
    ns[3:0] = ns[3:0] | tc;
    if (tg) m_ptr = ~m_ptr;
    if (wr) begin
      case (sel)
        3'd0: if (d == 8'h00 || d == 8'h04) m_cmd = d;
        3'd2: nm[ch] = d[2];
        3'd3: m_mode[ch] = d;
        3'd4: m_ptr = 1'b0;
        3'd5: begin m_ptr = 1'b0; ns = 8'h00; m_cmd = 8'h00; nm = 4'hF; end
        3'd6: nm = 4'h0;
        3'd7: nm = d[3:0];
        default: ;
      endcase
    end
    m_status = ns;
    m_mask = nm;
    @(posedge clk);
    #1;
    check_outputs();
  endtask

  task automatic idle();
    cyc(0, 0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h0, 0);
  endtask

  task automatic rd_status_expect(input string tag, input logic [7:0] exp);
    @(negedge clk);
    ctl_wr = 0; ctl_rd = 1; ctl_sel = 3'd0; tc_pulse = 0; hold_set = 0;
    hold_clr = 0; ptr_toggle = 0;
    #1;
    chk(tag, {24'h0, ctl_rdata}, {24'h0, exp});
    @(posedge clk); #1;
    ctl_rd = 0;
    m_status[3:0] = 4'h0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    rst_n = 0; ctl_wr = 0; ctl_rd = 0; ctl_sel = 0; ctl_wdata = 0;
    tc_pulse = 0; hold_set = 0; hold_clr = 0; ptr_toggle = 0;
    m_cmd = 0; m_status = 0; m_mask = 4'hF; m_ptr = 0;
    for (int c = 0; c < 4; c++) m_mode[c] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 mask", {28'h0, mask_o}, 32'hF);
    chk("R1 cmd", {24'h0, cmd_o}, 32'h0);
    chk("R1 verify", {28'h0, verify_o}, 32'hF);
    chk("R1 mode", mode_o, 32'h0);
    chk("R1 ptr", {31'h0, byte_ptr_o}, 32'h0);
    rd_status_expect("R1 status", 8'h00);

    // R2: accept 04, reject 05, accept 00
    cyc(1, 0, 3'd0, 8'h04, 0, 0, 0, 0); chk("R2 accept", {24'h0, cmd_o}, 32'h04);
    cyc(1, 0, 3'd0, 8'h05, 0, 0, 0, 0); chk("R2 reject", {24'h0, cmd_o}, 32'h04);
    cyc(1, 0, 3'd0, 8'h80, 0, 0, 0, 0); chk("R2 reject hi", {24'h0, cmd_o}, 32'h04);
    cyc(1, 0, 3'd0, 8'h00, 0, 0, 0, 0); chk("R2 zero", {24'h0, cmd_o}, 32'h00);

    // R5: mode to channel 2 with auto-init, non-verify
    cyc(1, 0, 3'd3, 8'h5E, 0, 0, 0, 0);
    chk("R5 ch2 autoinit", {28'h0, autoinit_o}, 32'h4);
    chk("R5 ch2 verify", {28'h0, verify_o}, 32'hB);
    cyc(1, 0, 3'd3, 8'h21, 0, 0, 0, 0);
    chk("R5 ch1 decr", {28'h0, decr_o}, 32'h2);

    // R11: tc on ch1 with status read in same cycle
    cyc(0, 0, 3'd0, 0, 4'h8, 0, 0, 0);
    cyc(0, 1, 3'd0, 0, 4'h2, 0, 0, 0);
    rd_status_expect("R11 tc kept over read", 8'h02);
    rd_status_expect("R9 tc cleared", 8'h00);

    // R3: request write on ch3 sets req and clears tc bit 3
    cyc(0, 0, 3'd0, 0, 4'h8, 0, 0, 0);
    cyc(1, 0, 3'd1, 8'h07, 0, 0, 0, 0);
    chk("R3 req set", {28'h0, req_o}, 32'h8);
    rd_status_expect("R3 tc cleared by request", 8'h80);
    rd_status_expect("R9 req kept", 8'h80);
    // R11: tc beats request-write clear on the same channel
    cyc(1, 0, 3'd1, 8'h03, 4'h8, 0, 0, 0);
    rd_status_expect("R11 tc over request", 8'h08);

    // R10: set and release same cycle, set wins; release beats request write
    cyc(0, 0, 3'd0, 0, 0, 4'h1, 4'h1, 0);
    chk("R10 set wins", {28'h0, req_o}, 32'h1);
    cyc(1, 0, 3'd1, 8'h04, 0, 0, 4'h1, 0);
    chk("R10 release over request", {28'h0, req_o}, 32'h0);

    // R4 / R8 / R12
    cyc(1, 0, 3'd7, 8'hA5, 0, 0, 0, 0); chk("R8 write all", {28'h0, mask_o}, 32'h5);
    cyc(1, 0, 3'd2, 8'h05, 0, 0, 0, 0); chk("R4 set bit1", {28'h0, mask_o}, 32'h7);
    cyc(1, 0, 3'd2, 8'h00, 0, 0, 0, 0); chk("R4 clear bit0", {28'h0, mask_o}, 32'h6);
    cyc(0, 1, 3'd1, 0, 0, 0, 0, 0);
    cyc(0, 1, 3'd6, 0, 0, 0, 0, 0);
    cyc(1, 0, 3'd6, 8'hFF, 0, 0, 0, 0); chk("R8 clear all", {28'h0, mask_o}, 32'h0);

    // R6: toggle then clear
    cyc(0, 0, 3'd0, 0, 0, 0, 0, 1); chk("R6 toggle", {31'h0, byte_ptr_o}, 32'h1);
    cyc(1, 0, 3'd4, 8'h00, 0, 0, 0, 0); chk("R6 clear", {31'h0, byte_ptr_o}, 32'h0);

    // R7: master reset overrides hold and tc, keeps modes
    cyc(0, 0, 3'd0, 0, 0, 0, 0, 1);
    cyc(1, 0, 3'd0, 8'h04, 0, 0, 0, 0);
    cyc(1, 0, 3'd5, 8'h00, 4'hF, 4'hF, 0, 1);
    chk("R7 mask", {28'h0, mask_o}, 32'hF);
    chk("R7 cmd", {24'h0, cmd_o}, 32'h0);
    chk("R7 ptr", {31'h0, byte_ptr_o}, 32'h0);
    chk("R7 modes kept", {28'h0, autoinit_o}, 32'h4);
    rd_status_expect("R7 status", 8'h00);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      bit w, r, t;
      logic [2:0] s;
      logic [7:0] d;
      logic [3:0] tc, hs, hc;
      w  = ($urandom % 3) == 0;
      r  = ($urandom % 4) == 0;
      s  = 3'($urandom % 8);
      if (w && s == 3'd5 && ($urandom % 4) != 0) s = 3'd2;
      d  = 8'($urandom);
      if (w && s == 3'd0 && ($urandom % 2) == 0) d = ($urandom % 2) ? 8'h04 : 8'h00;
      tc = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      hs = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      hc = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      t  = ($urandom % 6) == 0;
      cyc(w, r, s, d, tc, hs, hc, t);
    end
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule